// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave side of a two-wire serial bus, placed in front of a byte-addressable storage array. Clock and data are sampled on the system clock and cleaned by a short filter. The block finds start and stop conditions and checks a device-select byte against three strap inputs. It then takes a two-byte word address, accepts write data into a page buffer, or returns read data by pulling the data line low through an open-drain enable.

A write fills a 32-byte page buffer. The word pointer's low five bits wrap inside the page and its upper eight bits stay fixed. The buffered bytes are copied into the array only when a clean stop ends the transfer. After that copy, a timed busy window runs, and during it the block declines every device select. Reads can start at the retained pointer, or at a freshly loaded address after a repeated start. A read continues byte after byte while the master acknowledges. The array depth is a parameter: `MEM_AW` = 13 gives the full 8192 bytes, and smaller values alias the 13-bit word address onto the array.

The FSM states are: `ST_IDLE` (ignore the bus), `ST_DEVSEL` (shift select byte), `ST_DEV_ACK` (acknowledge select), `ST_ADDR_HI` / `ST_AHI_ACK` (upper address byte and its acknowledge), `ST_ADDR_LO` / `ST_ALO_ACK` (lower address byte and its acknowledge), `ST_WDATA` / `ST_WD_ACK` (write byte and its acknowledge), and `ST_RDATA` / `ST_RD_ACK` (send byte, then sample the master's answer).

Transitions:
- A start from any state leads to `ST_DEVSEL`, and a stop from any state leads to `ST_IDLE`.
- At the falling edge that closes a byte, each byte state moves to its acknowledge state. A select byte that does not match goes to `ST_IDLE` instead.
- At the falling edge that closes an acknowledge, the next state depends on where the block is:
  - `ST_DEV_ACK` moves to `ST_RDATA` for a read or `ST_ADDR_HI` for a write.
  - `ST_AHI_ACK` moves to `ST_ADDR_LO`.
  - `ST_ALO_ACK` moves to `ST_WDATA`.
  - `ST_WD_ACK` moves to `ST_WDATA`.
  - `ST_RD_ACK` moves to `ST_RDATA` when the master acknowledged, or `ST_IDLE` when it did not.

Top module: `eeprom_twi_slave`

## Requirements
- R1: A pulse on the sampled data line lasting two system clocks or less has no effect. A data bit of 1 that carries such a low pulse while the clock line is high is still stored as 1, and the write still commits.
- R2: The block acknowledges a select byte (bits 7..1 = 1010 followed by `dev_addr_i` bits 2..0, bit 0 = 1 for read) only when those bits match. A mismatch leaves the data line released during the acknowledge clock.
- R3: The pull-down enable `sda_oe` only ever asserts while the filtered clock is low. It is never asserted during a clock-high phase in which the master drives data or its acknowledge.
- R4: The word address is 13 bits: bits 4..0 of the first address byte, followed by all of the second byte. Bits 7..5 of the first byte are ignored. A single-byte write followed by a random read at the same address returns that byte.
- R5: During a write, each received byte goes to the pointer's low five bits, which then increment modulo 32. The upper eight bits do not change, so a 32-byte write that starts mid-page wraps to the page start and leaves neighbouring pages untouched.
- R6: A write of fewer than 32 bytes changes only the addressed bytes. Every other byte of the page keeps its value (0xFF after reset).
- R7: When `wp_i` is high at the stop, no byte is written and no busy window starts, so an immediately following select is acknowledged.
- R8: After a committed write, every select is declined for `BUSY_CYCLES` system clocks. After that window, selects are acknowledged again.
- R9: During a read, the 13-bit pointer increments (wrapping from 0x1FFF to 0x0000) after each byte that the master acknowledges. A byte the master does not acknowledge ends the read.
- R10: A read select with no address phase (current-address read) starts at the retained pointer: the address of the last byte read, or the next write slot after a write.
- R11: A stop or start that arrives two or more bits into a write byte discards the whole transfer. Memory is unchanged and no busy window starts.
- R12: After reset the data line is released and every array byte reads 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as sampled |
| sda_i | input | 1 | Bus data line as sampled (wired-AND level) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| dev_addr_i | input | 3 | Strap value the select byte must match |
| wp_i | input | 1 | High blocks all memory writes |

## Verification
The hardest situation to reach from the ports is a stop or start that lands mid-byte in a write. Without care it looks the same as a legal stop. The bench drives a partial byte of a few bits from its bit-level master, ends it with a stop or a repeated start, and then proves that nothing was written: the very next select is acknowledged (no busy window) and a read-back returns the old bytes. A second hard case is a filtered glitch riding a clock-high phase. The bench injects it by switching its data drive for two system clocks in the middle of that phase.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

    localparam int WORD_AW    = 13;
    localparam int PAGE_AW    = 5;
    localparam int PAGE_BYTES = 1 << PAGE_AW;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_DEV_ACK,
        ST_ADDR_HI,
        ST_AHI_ACK,
        ST_ADDR_LO,
        ST_ALO_ACK,
        ST_WDATA,
        ST_WD_ACK,
        ST_RDATA,
        ST_RD_ACK
    } fsm_t;

endpackage

// File: rtl/twi_glitch_filter.sv
module twi_glitch_filter #(
    parameter int SYNC = 2,
    parameter int TAPS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    logic [SYNC-1:0] sync_q;
    logic [TAPS-1:0] hist_q;
    logic            filt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            filt_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC-2:0], raw_i};
            hist_q <= {hist_q[TAPS-2:0], sync_q[SYNC-1]};
            if (&hist_q)
                filt_q <= 1'b1;
            else if (~|hist_q)
                filt_q <= 1'b0;
        end
    end

    assign filt_o = filt_q;
endmodule

// File: rtl/twi_eeprom_array.sv
module twi_eeprom_array #(
    parameter int AW = 10,
    parameter int WA = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [WA-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [WA-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
        end else if (we) begin
            mem_q[int'(waddr) % DEPTH] <= wdata;
        end
    end

    assign rdata = mem_q[int'(raddr) % DEPTH];
endmodule

// File: rtl/eeprom_twi_slave.sv
module eeprom_twi_slave
    import twi_eeprom_pkg::*;
#(
    parameter int MEM_AW      = 10,
    parameter int BUSY_CYCLES = 4000,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_TAPS   = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [2:0] dev_addr_i,
    input  logic       wp_i
);
    localparam int BUSY_EFF = (BUSY_CYCLES < PAGE_BYTES) ? PAGE_BYTES : BUSY_CYCLES;
    localparam int BUSY_W   = $clog2(BUSY_EFF + 1);
    localparam int PG_W     = WORD_AW - PAGE_AW;

    // input conditioning, one filter per bus line
    logic [1:0] raw_bus, filt_bus;
    assign raw_bus = {scl_i, sda_i};
    for (genvar g = 0; g < 2; g++) begin : g_filt
        twi_glitch_filter #(.SYNC(SYNC_STAGES), .TAPS(FILT_TAPS)) u_filt (
            .clk(clk), .rst_n(rst_n), .raw_i(raw_bus[g]), .filt_o(filt_bus[g]));
    end

    logic scl_f, sda_f, scl_p, sda_p;
    assign scl_f = filt_bus[1];
    assign sda_f = filt_bus[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_f;
            sda_p <= sda_f;
        end
    end

    logic scl_rise, scl_fall, start_ev, stop_ev;
    assign scl_rise = scl_f & ~scl_p;
    assign scl_fall = ~scl_f & scl_p;
    assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
    assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;

    fsm_t                  state_q, state_d;
    logic [3:0]            cnt_q;
    logic [7:0]            shreg_q;
    logic                  oe_q, rw_q, mack_q;
    logic [WORD_AW-1:0]    addr_q, rd_addr;
    logic [7:0]            pbuf_q [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pvalid_q;
    logic [BUSY_W-1:0]     busy_q;
    logic                  commit_run_q;
    logic [PAGE_AW-1:0]    commit_idx_q;
    logic [PG_W-1:0]       commit_page_q;
    logic [7:0]            rd_byte;
    logic                  busy, sel_ack, commit_go, mem_we;

    assign busy      = (busy_q != '0);
    assign sel_ack   = (shreg_q[7:1] == {4'b1010, dev_addr_i}) && !busy;
    assign commit_go = stop_ev && (state_q == ST_WDATA) && (cnt_q <= 4'd1)
                       && (|pvalid_q) && !wp_i && !busy;
    assign rd_addr   = (state_q == ST_RD_ACK) ? addr_q + 1'b1 : addr_q;
    assign mem_we    = commit_run_q & pvalid_q[commit_idx_q];

    twi_eeprom_array #(.AW(MEM_AW), .WA(WORD_AW)) u_array (
        .clk(clk), .rst_n(rst_n), .we(mem_we),
        .waddr({commit_page_q, commit_idx_q}), .wdata(pbuf_q[commit_idx_q]),
        .raddr(rd_addr), .rdata(rd_byte));

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_ev)
            state_d = ST_DEVSEL;
        else if (stop_ev)
            state_d = ST_IDLE;
        else if (scl_fall) begin
            unique case (state_q)
                ST_IDLE:    state_d = ST_IDLE;
                ST_DEVSEL:  if (cnt_q == 4'd8) state_d = sel_ack ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK: state_d = rw_q ? ST_RDATA : ST_ADDR_HI;
                ST_ADDR_HI: if (cnt_q == 4'd8) state_d = ST_AHI_ACK;
                ST_AHI_ACK: state_d = ST_ADDR_LO;
                ST_ADDR_LO: if (cnt_q == 4'd8) state_d = ST_ALO_ACK;
                ST_ALO_ACK: state_d = ST_WDATA;
                ST_WDATA:   if (cnt_q == 4'd8) state_d = ST_WD_ACK;
                ST_WD_ACK:  state_d = ST_WDATA;
                ST_RDATA:   if (cnt_q == 4'd8) state_d = ST_RD_ACK;
                ST_RD_ACK:  state_d = mack_q ? ST_RDATA : ST_IDLE;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shreg_q  <= '0;
            oe_q     <= 1'b0;
            rw_q     <= 1'b0;
            mack_q   <= 1'b0;
            addr_q   <= '0;
            pvalid_q <= '0;
        end else if (start_ev || stop_ev) begin
            cnt_q <= '0;
            oe_q  <= 1'b0;
        end else if (scl_rise) begin
            unique case (state_q)
                ST_DEVSEL, ST_ADDR_HI, ST_ADDR_LO, ST_WDATA: begin
                    shreg_q <= {shreg_q[6:0], sda_f};
                    cnt_q   <= cnt_q + 1'b1;
                end
                ST_RDATA:  cnt_q  <= cnt_q + 1'b1;
                ST_RD_ACK: mack_q <= ~sda_f;
                default: ;
            endcase
        end else if (scl_fall) begin
            unique case (state_q)
                ST_DEVSEL: if (cnt_q == 4'd8) begin
                    rw_q <= shreg_q[0];
                    oe_q <= sel_ack;
                end
                ST_ADDR_HI: if (cnt_q == 4'd8) begin
                    addr_q[WORD_AW-1:8] <= shreg_q[WORD_AW-9:0];
                    oe_q <= 1'b1;
                end
                ST_ADDR_LO: if (cnt_q == 4'd8) begin
                    addr_q[7:0] <= shreg_q;
                    oe_q <= 1'b1;
                end
                ST_WDATA: if (cnt_q == 4'd8) begin
                    pbuf_q[addr_q[PAGE_AW-1:0]]   <= shreg_q;
                    pvalid_q[addr_q[PAGE_AW-1:0]] <= 1'b1;
                    addr_q[PAGE_AW-1:0]           <= addr_q[PAGE_AW-1:0] + 1'b1;
                    oe_q <= 1'b1;
                end
                ST_DEV_ACK: begin
                    cnt_q <= '0;
                    if (rw_q) begin
                        shreg_q <= rd_byte;
                        oe_q    <= ~rd_byte[7];
                    end else begin
                        oe_q    <= 1'b0;
                    end
                end
                ST_AHI_ACK, ST_WD_ACK: begin
                    cnt_q <= '0;
                    oe_q  <= 1'b0;
                end
                ST_ALO_ACK: begin
                    cnt_q    <= '0;
                    oe_q     <= 1'b0;
                    pvalid_q <= '0;
                end
                ST_RDATA: begin
                    if (cnt_q == 4'd8) begin
                        oe_q <= 1'b0;
                    end else begin
                        oe_q    <= ~shreg_q[6];
                        shreg_q <= {shreg_q[6:0], 1'b0};
                    end
                end
                ST_RD_ACK: begin
                    cnt_q <= '0;
                    if (mack_q) begin
                        addr_q  <= addr_q + 1'b1;
                        shreg_q <= rd_byte;
                        oe_q    <= ~rd_byte[7];
                    end else begin
                        oe_q    <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // self-timed write cycle: copy buffer, then hold busy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q        <= '0;
            commit_run_q  <= 1'b0;
            commit_idx_q  <= '0;
            commit_page_q <= '0;
        end else if (commit_go) begin
            busy_q        <= BUSY_W'(BUSY_EFF);
            commit_run_q  <= 1'b1;
            commit_idx_q  <= '0;
            commit_page_q <= addr_q[WORD_AW-1:PAGE_AW];
        end else begin
            if (busy) busy_q <= busy_q - 1'b1;
            if (commit_run_q) begin
                commit_idx_q <= commit_idx_q + 1'b1;
                if (&commit_idx_q) commit_run_q <= 1'b0;
            end
        end
    end

    assign sda_oe = oe_q;
endmodule

// File: rtl/eeprom_twi_checker.sv
module eeprom_twi_checker
    import twi_eeprom_pkg::*;
#(
    parameter int BW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          scl_f,
    input logic          sda_oe,
    input fsm_t          state_q,
    input logic [12:0]   addr_q,
    input logic [BW-1:0] busy_q,
    input logic          mem_we
);
    AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_f) else $error("pull-down raised with clock high"); // R3

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE |-> !sda_oe) else $error("line held in idle"); // R2

    AST_PAGE_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WDATA || state_q == ST_WD_ACK) &&
         ($past(state_q) == ST_WDATA || $past(state_q) == ST_WD_ACK))
        |-> addr_q[12:5] == $past(addr_q[12:5])) else $error("page bits moved"); // R5

    AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy_q != '0) else $error("array written outside write cycle"); // R8

    AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q != '0 |=> busy_q == $past(busy_q) - 1'b1) else $error("busy timer jumped"); // R8

    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DEV_ACK |-> busy_q == '0) else $error("select acked while busy"); // R8
endmodule

bind eeprom_twi_slave eeprom_twi_checker #(.BW(BUSY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(oe_q),
    .state_q(state_q), .addr_q(addr_q), .busy_q(busy_q), .mem_we(mem_we));

// File: tb/eeprom_twi_slave_tb_top.sv
module eeprom_twi_slave_tb_top;
    localparam int H    = 16;
    localparam int BUSY = 600;
    localparam int MAW  = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       wp = 1'b0;
    logic [2:0] dev = 3'b101;
    logic       sda_oe;
    logic       sda_bus;

    assign sda_bus = m_sda & ~sda_oe;
    always #4 clk = ~clk;

    eeprom_twi_slave #(.MEM_AW(MAW), .BUSY_CYCLES(BUSY)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .dev_addr_i(dev), .wp_i(wp));

    int          n_chk = 0, n_fail = 0;
    logic [7:0]  mmem [0:(1<<MAW)-1];
    logic [12:0] mptr = '0;
    logic [7:0]  wq[$];
    bit          may_drive = 1'b0;
    bit          mon_bad = 1'b0;

    function automatic int idx(input logic [12:0] a);
        return int'(a) % (1 << MAW);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // R3: slave must be released whenever the master owns a clock-high phase
    always @(negedge clk)
        if (rst_n && scl && !may_drive && sda_oe) mon_bad = 1'b1;

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    task automatic hp(); repeat (H) @(negedge clk); endtask

    task automatic start_c();
        may_drive = 1'b0;
        m_sda = 1'b1; hp(); scl = 1'b1; hp(); m_sda = 1'b0; hp(); scl = 1'b0; hp();
    endtask

    task automatic stop_c();
        may_drive = 1'b0;
        m_sda = 1'b0; hp(); scl = 1'b1; hp(); m_sda = 1'b1; hp();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
        may_drive = 1'b0;
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; hp(); scl = 1'b1;
            if (glitch && i == 4) begin
                repeat (5) @(negedge clk); m_sda = 1'b0;
                repeat (2) @(negedge clk); m_sda = b[i];
                repeat (H - 7) @(negedge clk);
            end else hp();
            scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        send_bits(b, 8, glitch);
        m_sda = 1'b1; may_drive = 1'b1; hp(); scl = 1'b1; hp();
        ack = !sda_bus; scl = 1'b0; may_drive = 1'b0;
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] b);
        may_drive = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hp(); scl = 1'b1; hp(); b[i] = sda_bus; scl = 1'b0;
        end
        may_drive = 1'b0; m_sda = !mack; hp(); scl = 1'b1; hp(); scl = 1'b0; m_sda = 1'b1;
    endtask

    task automatic addr_phase(input logic [12:0] a, input logic [2:0] junk, input string req);
        bit ack;
        send_byte({4'b1010, dev, 1'b0}, 1'b0, ack); chk(ack, "R2", ack, 1);
        send_byte({junk, a[12:8]}, 1'b0, ack);     chk(ack, req, ack, 1);
        send_byte(a[7:0], 1'b0, ack);              chk(ack, req, ack, 1);
        mptr = a;
    endtask

    task automatic write_tx(input logic [12:0] a, input logic [2:0] junk, input int glitch_at,
                            input bit do_wait, input string req);
        bit ack;
        start_c();
        addr_phase(a, junk, req);
        foreach (wq[i]) begin
            send_byte(wq[i], i == glitch_at, ack); chk(ack, req, ack, 1);
            mptr[4:0] = mptr[4:0] + 5'd1;
        end
        stop_c();
        if (!wp && wq.size() > 0) begin
            foreach (wq[i]) mmem[idx({a[12:5], 5'(a[4:0] + 5'(i))})] = wq[i];
            if (do_wait) repeat (BUSY + 40) @(negedge clk);
        end
    endtask

    task automatic read_seq(input int n, input string req);
        logic [7:0] b;
        for (int i = 0; i < n; i++) begin
            read_byte(i != n - 1, b);
            chk(b == mmem[idx(mptr)], req, b, mmem[idx(mptr)]);
            if (i != n - 1) mptr = mptr + 13'd1;
        end
        stop_c();
    endtask

    task automatic rand_read(input logic [12:0] a, input int n, input string req);
        bit ack;
        start_c();
        addr_phase(a, 3'b000, req);
        start_c();
        send_byte({4'b1010, dev, 1'b1}, 1'b0, ack); chk(ack, "R2", ack, 1);
        read_seq(n, req);
    endtask

    task automatic probe(input bit exp_ack, input string req);
        bit ack;
        start_c();
        send_byte({4'b1010, dev, 1'b0}, 1'b0, ack);
        chk(ack == exp_ack, req, ack, exp_ack);
        stop_c();
    endtask

    initial begin
        bit ack;
        for (int i = 0; i < (1 << MAW); i++) mmem[i] = 8'hFF;
        repeat (10) @(negedge clk);
        chk(sda_oe == 1'b0, "R12", sda_oe, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(sda_oe == 1'b0, "R12", sda_oe, 0);
        rand_read(13'h0040, 1, "R12");

        // R4: byte write with junk upper address bits, random read back
        wq = '{8'h5A};
        write_tx(13'h0123, 3'b111, -1, 1'b1, "R4");
        rand_read(13'h0123, 1, "R4");

        // R2: mismatching strap value is not acknowledged
        start_c();
        send_byte({4'b1010, dev ^ 3'b001, 1'b0}, 1'b0, ack);
        chk(!ack, "R2", ack, 0);
        stop_c();

        // R8: busy window declines selects, then ends
        wq = '{8'h11, 8'h22};
        write_tx(13'h0456, 3'b000, -1, 1'b0, "R8");
        probe(1'b0, "R8");
        repeat (BUSY + 40) @(negedge clk);
        probe(1'b1, "R8");
        rand_read(13'h0456, 2, "R8");

        // R5: full page from mid-page wraps inside the page
        wq = {};
        for (int i = 0; i < 32; i++) wq.push_back(8'(8'h80 + i));
        write_tx(13'h080B, 3'b000, -1, 1'b1, "R5");
        rand_read(13'h07FF, 34, "R5");

        // R6: partial page, wrapping at the end
        wq = '{8'hA1, 8'hA2, 8'hA3};
        write_tx(13'h0A1E, 3'b000, -1, 1'b1, "R6");
        rand_read(13'h0A00, 32, "R6");

        // R7: write protect
        wp = 1'b1;
        wq = '{8'h33};
        write_tx(13'h0123, 3'b000, -1, 1'b0, "R7");
        probe(1'b1, "R7");
        wp = 1'b0;
        rand_read(13'h0123, 1, "R7");

        // R9: sequential read across top of the address space
        wq = '{8'h71, 8'h72};
        write_tx(13'h1FFE, 3'b000, -1, 1'b1, "R9");
        wq = '{8'h73};
        write_tx(13'h0000, 3'b000, -1, 1'b1, "R9");
        rand_read(13'h1FFE, 4, "R9");

        // R10: current-address read from retained pointer
        start_c();
        send_byte({4'b1010, dev, 1'b1}, 1'b0, ack); chk(ack, "R10", ack, 1);
        read_seq(2, "R10");

        // R11: stop part-way through a byte
        start_c();
        addr_phase(13'h0300, 3'b000, "R11");
        send_byte(8'hC4, 1'b0, ack); chk(ack, "R11", ack, 1);
        send_bits(8'h5A, 4, 1'b0);
        stop_c();
        probe(1'b1, "R11");
        rand_read(13'h0300, 2, "R11");

        // R11: repeated start part-way through a byte
        start_c();
        addr_phase(13'h0310, 3'b000, "R11");
        send_byte(8'h9E, 1'b0, ack); chk(ack, "R11", ack, 1);
        send_bits(8'hF0, 3, 1'b0);
        start_c();
        send_byte({4'b1010, dev, 1'b1}, 1'b0, ack); chk(ack, "R11", ack, 1);
        mptr = 13'h0311;
        read_seq(1, "R11");
        probe(1'b1, "R11");
        rand_read(13'h0310, 1, "R11");

        // R1: short low pulse during a high data bit
        wq = '{8'h3C, 8'hE5};
        write_tx(13'h0150, 3'b000, 0, 1'b1, "R1");
        rand_read(13'h0150, 2, "R1");

        chk(!mon_bad, "R3", mon_bad, 0);
        finish_run();
    end
endmodule